// File: doc/BRIEF.md
# Picture-in-picture window, border and wipe generator

This block sits on the main-picture pixel clock and places a reduced sub-picture inside the main raster. It counts samples along each line and lines within each field from the falling edges of the main horizontal and vertical syncs. For every pixel it decides three things. First, whether the sub-picture covers the main picture there. Second, whether the pixel belongs to the border drawn around the sub-picture. Third, whether an edge band hides or blanks the pixel. Inside the readout area it presents a read address to the field store and passes the returned word to its sample output. On the border it outputs a programmable colour instead.

A box is anchored at an 8-bit line position and an 8-bit horizontal position. The box holds the readout area and a border ring around it. Up to four edge bands cut into the box from its sides, each band enabled separately. A mode input decides what a band does. In wipe mode a band removes the sub-picture from those pixels. In blanking mode a band keeps the sub-picture switched in but forces its sample to black.

Top module: `pip_window_gen`

## Requirements
- R1: While rst_n is low at a clock edge, every output register clears and both counters go to zero. A sync that is held low through reset counts as a falling edge on the first clock after reset.
- R2: The first edge that samples hsync_n low after it was high restarts the sample count at 0. Otherwise the sample count advances by one per clock and saturates at 1023. Each such hsync edge advances the line count, which saturates at 511. An edge that first samples vsync_n low restarts the line count at 0, and this takes priority when both syncs fall together.
- R3: The box starts at line vpos and at sample 2*hpos. It has a border 2 lines high at its top and bottom and 4 samples wide at its left and right. It encloses a readout area 268 samples wide. The readout area is 72 lines high when pal_mode=0 and 84 lines high when pal_mode=1.
- R4: One clock after the counters hold a position, rd_en is high exactly when that position is in the readout area. In that case rd_row and rd_col give the offset from the readout area's top-left corner. Otherwise both are 0.
- R5: sub_sel, frame_pin and out_sample appear two clocks after the counters hold a position. sub_sel is high only when display_en is set, the position lies in the box, and no wipe band covers it.
- R6: frame_pin is high exactly on the border pixels for which sub_sel is high.
- R7: When sub_sel is low, out_sample is 0. In the readout area, out_sample is the store_data word that was presented one clock after its address. On the border, out_sample is 0 when frame_en=0. When frame_en=1, the border takes a 4-bit colour in the upper bits of out_sample, with the lower 2 bits zero. The colour is chosen by the sample count modulo 4: 0 and 2 give col_y, 1 gives col_ry, 3 gives col_by.
- R8: A band is active only when wipe_en=1. edge_en[3] enables the top band, edge_en[2] the bottom band, edge_en[1] the left band and edge_en[0] the right band. A vertical band covers the 2*vrange lines of the box next to its side. A horizontal band covers the 2*hrange samples of the box next to its side. A range of 0 covers nothing.
- R9: With wipe_mode=1, a banded pixel drives sub_sel, frame_pin and out_sample low.
- R10: With wipe_mode=0, a banded pixel keeps sub_sel and frame_pin as they would be without bands, and out_sample is forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main-picture pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_n | input | 1 | Main horizontal sync, active low |
| vsync_n | input | 1 | Main vertical sync, active low |
| display_en | input | 1 | Sub-picture display enable |
| pal_mode | input | 1 | 1 selects the 84-line readout height, 0 the 72-line height |
| vpos | input | 8 | Box top line |
| hpos | input | 8 | Box left edge in units of 2 samples |
| frame_en | input | 1 | Paint the border with the colour registers |
| col_y | input | 4 | Border colour for luma phases |
| col_ry | input | 4 | Border colour for the R-Y phase |
| col_by | input | 4 | Border colour for the B-Y phase |
| wipe_en | input | 1 | Enable the edge bands |
| wipe_mode | input | 1 | 1 wipe, 0 blank |
| edge_en | input | 4 | Band enables: top, bottom, left, right from bit 3 down |
| vrange | input | 6 | Vertical band depth in units of 2 lines |
| hrange | input | 6 | Horizontal band depth in units of 2 samples |
| store_data | input | 6 | Store word for the address of the previous clock |
| rd_en | output | 1 | Read address valid |
| rd_row | output | 7 | Readout line offset |
| rd_col | output | 9 | Readout sample offset |
| sub_sel | output | 1 | Sub-picture/main-picture switch |
| frame_pin | output | 1 | Border position pulse |
| out_sample | output | 6 | Sample to the converter |

## Verification
A border pixel can also lie inside an edge band, and in that cycle the border and the band both claim the same outputs. The bench provokes this by pairing random band depths and edge enables with box positions whose border ring crosses the bands, in both wipe and blanking mode. Against its own model it judges that in wipe mode the band clears frame_pin together with sub_sel. In blanking mode it judges that frame_pin stays high while the border colour gives way to black. A second overlap is a falling vsync on the same edge as a falling hsync. Random sync streams produce it, and the bench judges it by the line count restarting at 0 rather than advancing, which shows in the later read rows.

// File: rtl/pip_pkg.sv
// Shared types for the picture-in-picture window generator.
package pip_pkg;

    // Colour phase of a sample, taken from the sample count modulo 4.
    typedef enum logic [1:0] {
        PH_Y0 = 2'd0,
        PH_RY = 2'd1,
        PH_Y1 = 2'd2,
        PH_BY = 2'd3
    } pip_phase_e;

    // Per-pixel decisions carried from the region decoder to the output stage.
    typedef struct packed {
        logic       show;   // sub-picture switched in
        logic       frame;  // shown border pixel
        logic       win;    // inside the readout area
        logic       blank;  // forced to black by a blanking band
        pip_phase_e phase;  // colour phase of the sample
    } pip_flags_t;

endpackage

// File: rtl/pip_raster_cnt.sv
// Raster position counters driven by main-picture sync.
// Assumes: syncs are already synchronous to clk and active low; only the
// first clock that sees a sync low is treated as its edge. Both counters
// saturate instead of wrapping when a sync goes missing.
module pip_raster_cnt #(
    parameter int H_W = 10,
    parameter int V_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hsync_n,
    input  logic           vsync_n,
    output logic [H_W-1:0] hcnt,
    output logic [V_W-1:0] vcnt
);
    localparam logic [H_W-1:0] HMAX = {H_W{1'b1}};
    localparam logic [V_W-1:0] VMAX = {V_W{1'b1}};

    logic hs_q, vs_q;
    logic h_fall, v_fall;

    assign h_fall = hs_q & ~hsync_n;
    assign v_fall = vs_q & ~vsync_n;

    // Remember the previous sync levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b1;
            vs_q <= 1'b1;
        end else begin
            hs_q <= hsync_n;
            vs_q <= vsync_n;
        end
    end

    // Sample counter: restart on hsync edge, otherwise count up and saturate.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hcnt <= '0;
        else if (h_fall)
            hcnt <= '0;
        else if (hcnt != HMAX)
            hcnt <= hcnt + 1'b1;
    end

    // Line counter: vsync edge restarts it and wins over an hsync advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vcnt <= '0;
        else if (v_fall)
            vcnt <= '0;
        else if (h_fall && vcnt != VMAX)
            vcnt <= vcnt + 1'b1;
    end

endmodule

// File: rtl/pip_region_dec.sv
// Combinational region decoder: classifies one raster position as box,
// readout area, border or edge band, and forms the store read address.
// Assumes: arithmetic widths leave headroom so that no box coordinate
// wraps for any position or range value.
module pip_region_dec
    import pip_pkg::*;
#(
    parameter int H_W       = 10,
    parameter int V_W       = 9,
    parameter int POS_W     = 8,
    parameter int RNG_W     = 6,
    parameter int WIN_COLS  = 268,
    parameter int ROWS_NTSC = 72,
    parameter int ROWS_PAL  = 84,
    parameter int FRM_V     = 2,
    parameter int FRM_H     = 4,
    parameter int ROW_AW    = 7,
    parameter int COL_AW    = 9
) (
    input  logic [H_W-1:0]    hcnt,
    input  logic [V_W-1:0]    vcnt,
    input  logic              display_en,
    input  logic              pal_mode,
    input  logic [POS_W-1:0]  vpos,
    input  logic [POS_W-1:0]  hpos,
    input  logic              wipe_en,
    input  logic              wipe_mode,
    input  logic [3:0]        edge_en,
    input  logic [RNG_W-1:0]  vrange,
    input  logic [RNG_W-1:0]  hrange,
    output pip_flags_t        flags,
    output logic              in_win,
    output logic [ROW_AW-1:0] row_off,
    output logic [COL_AW-1:0] col_off
);
    localparam int VE = V_W + 2;
    localparam int HE = H_W + 2;

    logic [VE-1:0] v, rows, box_t, win_t, win_end, box_b, d_top, d_bot, v_band;
    logic [HE-1:0] h, box_l, win_l, win_hend, box_r, d_lft, d_rgt, h_band;
    logic in_box, in_band, hidden;

    // Vertical geometry of the box and readout area.
    assign v       = VE'(vcnt);
    assign rows    = pal_mode ? VE'(ROWS_PAL) : VE'(ROWS_NTSC);
    assign box_t   = VE'(vpos);
    assign win_t   = box_t + VE'(FRM_V);
    assign win_end = win_t + rows;
    assign box_b   = win_end + VE'(FRM_V - 1);

    // Horizontal geometry: position is in units of two samples.
    assign h        = HE'(hcnt);
    assign box_l    = HE'({hpos, 1'b0});
    assign win_l    = box_l + HE'(FRM_H);
    assign win_hend = win_l + HE'(WIN_COLS);
    assign box_r    = win_hend + HE'(FRM_H - 1);

    assign in_box = (v >= box_t) && (v <= box_b) && (h >= box_l) && (h <= box_r);
    assign in_win = (v >= win_t) && (v < win_end) && (h >= win_l) && (h < win_hend);

    // Distances from the four box sides, meaningful only inside the box.
    assign d_top  = v - box_t;
    assign d_bot  = box_b - v;
    assign d_lft  = h - box_l;
    assign d_rgt  = box_r - h;
    assign v_band = VE'({vrange, 1'b0});
    assign h_band = HE'({hrange, 1'b0});

    // Union of the enabled edge bands.
    assign in_band = wipe_en && ((edge_en[3] && d_top < v_band) ||
                                 (edge_en[2] && d_bot < v_band) ||
                                 (edge_en[1] && d_lft < h_band) ||
                                 (edge_en[0] && d_rgt < h_band));
    assign hidden  = in_band && wipe_mode;

    // Pack the per-pixel decisions for the output stage.
    always_comb begin
        flags.show  = display_en && in_box && !hidden;
        flags.frame = display_en && in_box && !hidden && !in_win;
        flags.win   = in_win;
        flags.blank = in_band && !wipe_mode;
        flags.phase = pip_phase_e'(hcnt[1:0]);
    end

    assign row_off = in_win ? ROW_AW'(v - win_t) : '0;
    assign col_off = in_win ? COL_AW'(h - win_l) : '0;

endmodule

// File: rtl/pip_out_stage.sv
// Output stage: turns decoded flags and the store word into the switch,
// border pulse and output sample, all registered together.
// Assumes: store_data holds the word for the address presented one clock
// earlier, i.e. the store has a single cycle of read latency.
module pip_out_stage
    import pip_pkg::*;
#(
    parameter int COL_W    = 4,
    parameter int SAMPLE_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pip_flags_t          flags_q,
    input  logic [SAMPLE_W-1:0] store_data,
    input  logic                frame_en,
    input  logic [COL_W-1:0]    col_y,
    input  logic [COL_W-1:0]    col_ry,
    input  logic [COL_W-1:0]    col_by,
    output logic                sub_sel,
    output logic                frame_pin,
    output logic [SAMPLE_W-1:0] out_sample
);
    localparam int PAD = SAMPLE_W - COL_W;

    logic [COL_W-1:0]    colour;
    logic [SAMPLE_W-1:0] smp_d;

    // Pick the border colour for this sample's phase.
    always_comb begin
        case (flags_q.phase)
            PH_RY:   colour = col_ry;
            PH_BY:   colour = col_by;
            default: colour = col_y;
        endcase
    end

    // Sample priority: hidden, then blanked, then image, then border.
    always_comb begin
        if (!flags_q.show || flags_q.blank)
            smp_d = '0;
        else if (flags_q.win)
            smp_d = store_data;
        else if (frame_en)
            smp_d = SAMPLE_W'(colour) << PAD;
        else
            smp_d = '0;
    end

    // Register the three outputs together so they stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_sel    <= 1'b0;
            frame_pin  <= 1'b0;
            out_sample <= '0;
        end else begin
            sub_sel    <= flags_q.show;
            frame_pin  <= flags_q.frame;
            out_sample <= smp_d;
        end
    end

endmodule

// File: rtl/pip_window_gen.sv
// Top of the picture-in-picture window generator: raster counters, region
// decoder, a read-address register stage and the output stage.
// Assumes: store_data follows rd_row/rd_col by exactly one clock.
module pip_window_gen
    import pip_pkg::*;
#(
    parameter int H_W       = 10,
    parameter int V_W       = 9,
    parameter int POS_W     = 8,
    parameter int RNG_W     = 6,
    parameter int COL_W     = 4,
    parameter int SAMPLE_W  = 6,
    parameter int WIN_COLS  = 268,
    parameter int ROWS_NTSC = 72,
    parameter int ROWS_PAL  = 84,
    parameter int FRM_V     = 2,
    parameter int FRM_H     = 4,
    localparam int ROW_AW   = $clog2(ROWS_PAL),
    localparam int COL_AW   = $clog2(WIN_COLS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hsync_n,
    input  logic                vsync_n,
    input  logic                display_en,
    input  logic                pal_mode,
    input  logic [POS_W-1:0]    vpos,
    input  logic [POS_W-1:0]    hpos,
    input  logic                frame_en,
    input  logic [COL_W-1:0]    col_y,
    input  logic [COL_W-1:0]    col_ry,
    input  logic [COL_W-1:0]    col_by,
    input  logic                wipe_en,
    input  logic                wipe_mode,
    input  logic [3:0]          edge_en,
    input  logic [RNG_W-1:0]    vrange,
    input  logic [RNG_W-1:0]    hrange,
    input  logic [SAMPLE_W-1:0] store_data,
    output logic                rd_en,
    output logic [ROW_AW-1:0]   rd_row,
    output logic [COL_AW-1:0]   rd_col,
    output logic                sub_sel,
    output logic                frame_pin,
    output logic [SAMPLE_W-1:0] out_sample
);
    logic [H_W-1:0]    hcnt;
    logic [V_W-1:0]    vcnt;
    pip_flags_t        flags_d, flags_q;
    logic              win_d;
    logic [ROW_AW-1:0] row_d;
    logic [COL_AW-1:0] col_d;

    pip_raster_cnt #(.H_W(H_W), .V_W(V_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hsync_n (hsync_n),
        .vsync_n (vsync_n),
        .hcnt    (hcnt),
        .vcnt    (vcnt)
    );

    pip_region_dec #(
        .H_W(H_W), .V_W(V_W), .POS_W(POS_W), .RNG_W(RNG_W),
        .WIN_COLS(WIN_COLS), .ROWS_NTSC(ROWS_NTSC), .ROWS_PAL(ROWS_PAL),
        .FRM_V(FRM_V), .FRM_H(FRM_H), .ROW_AW(ROW_AW), .COL_AW(COL_AW)
    ) u_dec (
        .hcnt       (hcnt),
        .vcnt       (vcnt),
        .display_en (display_en),
        .pal_mode   (pal_mode),
        .vpos       (vpos),
        .hpos       (hpos),
        .wipe_en    (wipe_en),
        .wipe_mode  (wipe_mode),
        .edge_en    (edge_en),
        .vrange     (vrange),
        .hrange     (hrange),
        .flags      (flags_d),
        .in_win     (win_d),
        .row_off    (row_d),
        .col_off    (col_d)
    );

    // Address stage: present the read address and hold flags for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            rd_en   <= 1'b0;
            rd_row  <= '0;
            rd_col  <= '0;
        end else begin
            flags_q <= flags_d;
            rd_en   <= win_d;
            rd_row  <= row_d;
            rd_col  <= col_d;
        end
    end

    pip_out_stage #(.COL_W(COL_W), .SAMPLE_W(SAMPLE_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags_q    (flags_q),
        .store_data (store_data),
        .frame_en   (frame_en),
        .col_y      (col_y),
        .col_ry     (col_ry),
        .col_by     (col_by),
        .sub_sel    (sub_sel),
        .frame_pin  (frame_pin),
        .out_sample (out_sample)
    );

endmodule

// File: rtl/pip_window_chk.sv
// Property checker for pip_window_gen, attached through bind below.
// Assumes: hcnt and vcnt are the top's internal raster counters.
module pip_window_chk #(
    parameter int H_W       = 10,
    parameter int V_W       = 9,
    parameter int SAMPLE_W  = 6,
    parameter int WIN_COLS  = 268,
    parameter int ROWS_NTSC = 72,
    parameter int ROWS_PAL  = 84,
    parameter int ROW_AW    = 7,
    parameter int COL_AW    = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hsync_n,
    input logic                vsync_n,
    input logic                display_en,
    input logic                pal_mode,
    input logic [H_W-1:0]      hcnt,
    input logic [V_W-1:0]      vcnt,
    input logic                rd_en,
    input logic [ROW_AW-1:0]   rd_row,
    input logic [COL_AW-1:0]   rd_col,
    input logic                sub_sel,
    input logic                frame_pin,
    input logic [SAMPLE_W-1:0] out_sample
);
    // R2: a vsync edge restarts the line count on the next clock.
    assert_vsync_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |=> (vcnt == '0));

    // R2: an hsync edge restarts the sample count on the next clock.
    assert_hsync_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |=> (hcnt == '0));

    // R4: a valid address stays inside the larger readout area.
    assert_addr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_row < ROWS_PAL && rd_col < WIN_COLS));

    // R4: the shorter height applies when the short mode was selected.
    assert_short_rows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !$past(pal_mode)) |-> (rd_row < ROWS_NTSC));

    // R4: without a valid address both offsets read zero.
    assert_addr_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_row == '0 && rd_col == '0));

    // R5: with display disabled two clocks back the switch is off.
    assert_display_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(display_en, 2) |-> !sub_sel);

    // R6: the border pulse never appears without the switch.
    assert_frame_in_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pin |-> sub_sel);

    // R7: a non-black sample only goes out while the switch is on.
    assert_dark_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sample != '0) |-> sub_sel);

endmodule

bind pip_window_gen pip_window_chk #(
    .H_W(H_W), .V_W(V_W), .SAMPLE_W(SAMPLE_W), .WIN_COLS(WIN_COLS),
    .ROWS_NTSC(ROWS_NTSC), .ROWS_PAL(ROWS_PAL), .ROW_AW(ROW_AW), .COL_AW(COL_AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsync_n    (hsync_n),
    .vsync_n    (vsync_n),
    .display_en (display_en),
    .pal_mode   (pal_mode),
    .hcnt       (hcnt),
    .vcnt       (vcnt),
    .rd_en      (rd_en),
    .rd_row     (rd_row),
    .rd_col     (rd_col),
    .sub_sel    (sub_sel),
    .frame_pin  (frame_pin),
    .out_sample (out_sample)
);

// File: tb/tb_pip_window_gen.sv
module tb_pip_window_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hsync_n, vsync_n, display_en, pal_mode, frame_en;
    logic [7:0] vpos, hpos;
    logic [3:0] col_y, col_ry, col_by, edge_en;
    logic       wipe_en, wipe_mode;
    logic [5:0] vrange, hrange, store_data;
    logic       rd_en, sub_sel, frame_pin;
    logic [6:0] rd_row;
    logic [8:0] rd_col;
    logic [5:0] out_sample;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    string scen = "R1 reset";

    // Model state: counters, edge memories, address stage, output stage.
    int mh, mv;
    bit hs_q, vs_q;
    bit a_show, a_frame, a_win, a_blank, a_en;
    int a_phase, a_row, a_col;
    bit b_sel, b_fp;
    int b_smp;

    always #2 clk = ~clk;

    pip_window_gen dut (
        .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .display_en(display_en), .pal_mode(pal_mode), .vpos(vpos), .hpos(hpos),
        .frame_en(frame_en), .col_y(col_y), .col_ry(col_ry), .col_by(col_by),
        .wipe_en(wipe_en), .wipe_mode(wipe_mode), .edge_en(edge_en),
        .vrange(vrange), .hrange(hrange), .store_data(store_data),
        .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col), .sub_sel(sub_sel),
        .frame_pin(frame_pin), .out_sample(out_sample)
    );

    function automatic logic [5:0] store_word(int r, int c);
        return 6'((r * 7 + c * 3 + 5) & 63);
    endfunction

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            if (n_fail <= 20)
                $display("FAIL %s/%s got %0d expected %0d at %0t", scen, req, got, exp, $time);
        end
    endtask

    // One clock: predict from the requirements, pass the edge, compare.
    task automatic tick();
        int rows, bt, wt, we, bb, bl, wl, wre, br, nh, nv, colr;
        bit inbox, inwin, band, hidden;
        bit n_show, n_frame, n_win, n_blank, n_en, n_sel, n_fp, hf, vf;
        int n_phase, n_row, n_col, n_smp;
        // R3: geometry of box, border and readout area.
        rows = pal_mode ? 84 : 72;
        bt = vpos; wt = bt + 2; we = wt + rows; bb = we + 1;
        bl = 2 * hpos; wl = bl + 4; wre = wl + 268; br = wre + 3;
        inbox = (mv >= bt) && (mv <= bb) && (mh >= bl) && (mh <= br);
        inwin = (mv >= wt) && (mv < we) && (mh >= wl) && (mh < wre);
        // R8: union of enabled bands.
        band = inbox && wipe_en &&
               ((edge_en[3] && (mv - bt) < 2 * vrange) ||
                (edge_en[2] && (bb - mv) < 2 * vrange) ||
                (edge_en[1] && (mh - bl) < 2 * hrange) ||
                (edge_en[0] && (br - mh) < 2 * hrange));
        hidden  = band && wipe_mode;           // R9
        n_show  = display_en && inbox && !hidden;
        n_frame = n_show && !inwin;
        n_win   = inwin;
        n_blank = band && !wipe_mode;          // R10
        n_phase = mh % 4;
        n_en    = inwin;
        n_row   = inwin ? mv - wt : 0;
        n_col   = inwin ? mh - wl : 0;
        // R7: output sample from the address-stage state.
        case (a_phase)
            1: colr = col_ry;
            3: colr = col_by;
            default: colr = col_y;
        endcase
        if (!a_show || a_blank) n_smp = 0;
        else if (a_win) n_smp = store_data;
        else if (frame_en) n_smp = colr * 4;
        else n_smp = 0;
        n_sel = a_show;
        n_fp  = a_frame;
        // R2: counter update.
        hf = hs_q && !hsync_n;
        vf = vs_q && !vsync_n;
        nh = hf ? 0 : (mh == 1023 ? 1023 : mh + 1);
        nv = vf ? 0 : (hf ? (mv == 511 ? 511 : mv + 1) : mv);
        @(negedge clk);
        if (!rst_n) begin
            mh = 0; mv = 0; hs_q = 1; vs_q = 1;
            a_show = 0; a_frame = 0; a_win = 0; a_blank = 0; a_en = 0;
            a_phase = 0; a_row = 0; a_col = 0;
            b_sel = 0; b_fp = 0; b_smp = 0;
        end else begin
            mh = nh; mv = nv; hs_q = hsync_n; vs_q = vsync_n;
            a_show = n_show; a_frame = n_frame; a_win = n_win; a_blank = n_blank;
            a_en = n_en; a_phase = n_phase; a_row = n_row; a_col = n_col;
            b_sel = n_sel; b_fp = n_fp; b_smp = n_smp;
        end
        chk("R4 rd_en", rd_en, a_en);
        chk("R4 rd_row", rd_row, a_row);
        chk("R4 rd_col", rd_col, a_col);
        chk("R5 sub_sel", sub_sel, b_sel);
        chk("R6 frame_pin", frame_pin, b_fp);
        chk("R7 out_sample", out_sample, b_smp);
        store_data = store_word(a_row, a_col);
    endtask

    task automatic run_line(int len, bit with_v);
        for (int c = 0; c < len; c++) begin
            hsync_n = (c < 2) ? 1'b0 : 1'b1;
            vsync_n = (with_v && c < 2) ? 1'b0 : 1'b1;
            tick();
        end
    endtask

    task automatic run_field(int len, int lines);
        for (int l = 0; l < lines; l++) run_line(len, l == 0);
    endtask

    task automatic rand_colours();
        col_y = 4'($urandom); col_ry = 4'($urandom); col_by = 4'($urandom);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; hsync_n = 0; vsync_n = 1; display_en = 1; pal_mode = 1;
        vpos = 0; hpos = 0; frame_en = 1; col_y = 4'hA; col_ry = 4'h5; col_by = 4'hC;
        wipe_en = 0; wipe_mode = 0; edge_en = 0; vrange = 0; hrange = 0; store_data = 0;
        mh = 0; mv = 0; hs_q = 1; vs_q = 1;
        a_show = 0; a_frame = 0; a_win = 0; a_blank = 0; a_en = 0;
        a_phase = 0; a_row = 0; a_col = 0; b_sel = 0; b_fp = 0; b_smp = 0;

        // R1: reset clears outputs even with display and sync active.
        repeat (3) tick();
        chk("R1 sub_sel", sub_sel, 0);
        chk("R1 rd_en", rd_en, 0);
        chk("R1 out_sample", out_sample, 0);
        rst_n = 1;

        // R3: tall mode, box near top-left, short lines cover the left border.
        scen = "R3 tall short lines";
        vpos = 3; hpos = 2;
        run_field(40, 95);

        // R3: short mode at a high line position.
        scen = "R3 short mode low box";
        pal_mode = 0; vpos = 250; hpos = 0; frame_en = 0;
        run_field(30, 340);

        // R3/R7: long lines reach the right border at random positions.
        scen = "R3 right edge";
        frame_en = 1; pal_mode = 1; vpos = 1;
        for (int k = 0; k < 3; k++) begin
            hpos = 8'($urandom_range(0, 120));
            rand_colours();
            run_field(2 * hpos + 300, 8);
        end

        // R9: wipe mode, one directed all-edges case then random bands.
        scen = "R9 wipe";
        wipe_en = 1; wipe_mode = 1; hpos = 0; pal_mode = 0;
        for (int k = 0; k < 2; k++) begin
            vpos = 8'($urandom_range(0, 3));
            edge_en = (k == 0) ? 4'b1111 : 4'($urandom);
            vrange  = (k == 0) ? 6'd5 : 6'($urandom_range(0, 30));
            hrange  = (k == 0) ? 6'd7 : 6'($urandom_range(0, 60));
            rand_colours();
            run_field(285, 80);
        end

        // R10: blanking mode; border pixels inside bands keep the pulse.
        scen = "R10 blank";
        wipe_mode = 0;
        for (int k = 0; k < 2; k++) begin
            vpos = 8'($urandom_range(0, 3));
            edge_en = (k == 0) ? 4'b1010 : 4'($urandom);
            vrange  = 6'($urandom_range(1, 30));
            hrange  = 6'($urandom_range(1, 60));
            rand_colours();
            run_field(285, 80);
        end

        // R8: bands off when wipe_en is low, and a zero range covers nothing.
        scen = "R8 disabled bands";
        wipe_en = 0; wipe_mode = 1; edge_en = 4'b1111; vrange = 6'd10; hrange = 6'd10;
        vpos = 2; hpos = 1;
        run_field(40, 95);
        scen = "R8 zero range";
        wipe_en = 1; vrange = 0; hrange = 0;
        run_field(40, 95);

        // R5: display disabled keeps the switch off everywhere.
        scen = "R5 display off";
        wipe_en = 0; display_en = 0;
        run_field(40, 95);

        // R2: random syncs, including both falling together, then saturation.
        scen = "R2 random sync";
        display_en = 1; vpos = 0; hpos = 0; pal_mode = 1;
        for (int k = 0; k < 3000; k++) begin
            hsync_n = ($urandom_range(0, 9) != 0);
            vsync_n = ($urandom_range(0, 60) != 0);
            if ($urandom_range(0, 99) == 0) begin hsync_n = 0; vsync_n = 0; end
            tick();
        end
        scen = "R2 saturation";
        hsync_n = 0; vsync_n = 0; tick(); tick();
        hsync_n = 1; vsync_n = 1;
        repeat (1100) tick();
        run_field(300, 3);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired in %s", scen);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule